// File: doc/BRIEF.md
# Serial Register-Access Slave

This block is the slave end of a chip-select-framed serial link. Through it a host microcontroller reads and writes an internal register bank. The host lowers the active-low select and clocks in one address byte, most significant bit first. That byte alone fixes what follows:

- no data at all, for a command;
- one or two write bytes, received on the same line;
- one or two read bytes, returned on a separate reply line.

Raising the select ends the transaction at any point and clears all progress.

On the bank side the block shows the current register address. A write is delivered as one strobe with its data, and only once every byte the register needs has arrived. The general reset command is delivered as a pulse. For reads, the bank supplies a 16-bit word. The word is fetched half a serial clock after the address byte completes, and it is then shifted out on falling serial-clock edges, so each bit is stable while the clock is high. Outside read data bits the reply line is not driven; an enable output tells the pad when to drive it.

Top module: `sreg_serial_slave`

## Requirements
- R1: The first 8 rising serial-clock edges after select falls capture the address byte, MSB first. That byte appears on reg_addr right after the 8th rising edge.
- R2: Address 0x01 is a general reset command. cmd_pulse goes high after the 8th rising edge and stays high until the next rising edge or until select rises. Any later bits of that frame produce no write strobe and no reply.
- R3: Addresses 0x80 to 0x9F are 8-bit write registers. wr_stb goes high once, after the 16th rising edge, with wr_data = {8'h00, data byte}. The data byte is received MSB first.
- R4: Addresses 0xA0 to 0xBF are 16-bit write registers. wr_stb goes high once, after the 24th rising edge, with wr_data = {first byte, second byte}: the upper byte comes first.
- R5: A write strobe fires only after the register's full byte count. If select rises earlier, no strobe fires. Surplus bits after the count add no second strobe. Each strobe lasts until the next rising edge or until select rises.
- R6: Addresses 0xC0 to 0xDF are 8-bit read registers. reply_q returns rd_data[7:0] MSB first. The first bit is driven on the falling edge after the 8th rising edge, and each later bit changes on a falling edge.
- R7: Addresses 0xE0 to 0xFF are 16-bit read registers. reply_q returns all 16 bits of rd_data, MSB first, on the same timing as R6.
- R8: reply_oe is high only while read data bits are being shifted. It falls on the falling edge after the last read bit, or when select rises, and it is never high together with wr_stb.
- R9: Every other address (0x00, 0x02 to 0x7F) is ignored: no wr_stb, no cmd_pulse, and reply_oe stays low.
- R10: The serial clock may idle high or low around a transaction, and gaps of any length between bytes do not change the result.
- R11: While rst_n is low, wr_stb, cmd_pulse and reply_oe are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock from the host |
| rst_n | input | 1 | Asynchronous active-low system reset |
| cs_n | input | 1 | Active-low select that frames a transaction |
| cmd_in | input | 1 | Serial address and write data, sampled on the rising edge |
| rd_data | input | 16 | Read word from the register bank for reg_addr |
| reply_q | output | 1 | Serial read data, updated on the falling edge |
| reply_oe | output | 1 | Output enable for the reply pad |
| reg_addr | output | 8 | Address byte of the current transaction |
| wr_data | output | 16 | Write data, valid while wr_stb is high |
| wr_stb | output | 1 | Write strobe, one per completed write |
| cmd_pulse | output | 1 | General reset command pulse to the bank |

## Verification
Two events can fall together: a write strobe completing, and either the frame ending or surplus bits arriving right after the last counted rising edge. The bench provokes this with frames that stop exactly at the byte count, one to four bits short of it, and a full byte beyond it. Each kind is sent with the serial clock idling high and idling low, and with random gaps between bytes. The bench judges each frame by the number of strobes seen, which must be one or zero, and by the address and data captured at that strobe.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int BYTE_W     = 8;
  localparam int MAX_BYTES  = 2;
  localparam int WORD_W     = BYTE_W * MAX_BYTES;
  localparam int FRAME_BITS = BYTE_W * (1 + MAX_BYTES);
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam int LEFT_W     = $clog2(WORD_W + 1);

  typedef enum logic [2:0] {
    CLS_NONE,
    CLS_CMD,
    CLS_WR8,
    CLS_WR16,
    CLS_RD8,
    CLS_RD16
  } acc_cls_e;

  function automatic logic cls_is_read(input acc_cls_e c);
    return (c == CLS_RD8) || (c == CLS_RD16);
  endfunction
endpackage

// File: rtl/sreg_decode.sv
module sreg_decode
  import sreg_pkg::*;
#(
  parameter logic [BYTE_W-1:0] RST_CODE = 8'h01
) (
  input  logic [BYTE_W-1:0] addr,
  output acc_cls_e          cls
);
  // Class is taken from the top three address bits; one code is a command.
  always_comb begin
    cls = CLS_NONE;
    if (addr == RST_CODE) begin
      cls = CLS_CMD;
    end else begin
      unique case (addr[BYTE_W-1 -: 3])
        3'b100:  cls = CLS_WR8;
        3'b101:  cls = CLS_WR16;
        3'b110:  cls = CLS_RD8;
        3'b111:  cls = CLS_RD16;
        default: cls = CLS_NONE;
      endcase
    end
  end
endmodule

// File: rtl/sreg_rx.sv
module sreg_rx
  import sreg_pkg::*;
(
  input  logic              sclk,
  input  logic              arst_n,
  input  logic              cmd_in,
  output logic [BYTE_W-1:0] reg_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              wr_stb,
  output logic              cmd_pulse,
  output acc_cls_e          cls,
  output logic              addr_ready
);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ADDR_DONE = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ONE_LAST  = CNT_W'(2 * BYTE_W - 1);
  localparam logic [CNT_W-1:0] TWO_LAST  = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_SAT   = CNT_W'(FRAME_BITS);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] abyte_q, abyte_d, abyte_nx;
  logic [BYTE_W-1:0] addr_q, addr_d;
  logic [WORD_W-1:0] data_q, data_d;
  acc_cls_e          cls_q, cls_d, cls_nx;
  logic              stb_q, stb_d, cmd_q, cmd_d;
  logic              addr_en, data_en;

  assign abyte_nx = {abyte_q[BYTE_W-2:0], cmd_in};

  sreg_decode u_decode (
    .addr (abyte_nx),
    .cls  (cls_nx)
  );

  always_comb begin
    addr_en = (cnt_q == ADDR_LAST);
    data_en = (cnt_q >= ADDR_DONE) && (cnt_q < CNT_SAT);
    cnt_d   = (cnt_q == CNT_SAT) ? cnt_q : cnt_q + 1'b1;
    abyte_d = (cnt_q < ADDR_DONE) ? abyte_nx : abyte_q;
    addr_d  = addr_en ? abyte_nx : addr_q;
    cls_d   = addr_en ? cls_nx : cls_q;
    data_d  = data_en ? {data_q[WORD_W-2:0], cmd_in} : data_q;
    stb_d   = ((cls_q == CLS_WR8)  && (cnt_q == ONE_LAST)) ||
              ((cls_q == CLS_WR16) && (cnt_q == TWO_LAST));
    cmd_d   = addr_en && (cls_nx == CLS_CMD);
  end

  always_ff @(posedge sclk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q   <= '0;
      abyte_q <= '0;
      addr_q  <= '0;
      cls_q   <= CLS_NONE;
      data_q  <= '0;
      stb_q   <= 1'b0;
      cmd_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      abyte_q <= abyte_d;
      addr_q  <= addr_d;
      cls_q   <= cls_d;
      data_q  <= data_d;
      stb_q   <= stb_d;
      cmd_q   <= cmd_d;
    end
  end

  assign reg_addr   = addr_q;
  assign wr_data    = data_q;
  assign wr_stb     = stb_q;
  assign cmd_pulse  = cmd_q;
  assign cls        = cls_q;
  assign addr_ready = (cnt_q == ADDR_DONE);
endmodule

// File: rtl/sreg_tx.sv
module sreg_tx
  import sreg_pkg::*;
(
  input  logic              sclk,
  input  logic              arst_n,
  input  logic              addr_ready,
  input  acc_cls_e          cls,
  input  logic [WORD_W-1:0] rd_data,
  output logic              reply_q,
  output logic              reply_oe
);
  logic [WORD_W-1:0] sh_q, sh_d;
  logic [LEFT_W-1:0] left_q, left_d;
  logic              oe_q, oe_d;
  logic              load;

  always_comb begin
    load   = addr_ready && cls_is_read(cls) && !oe_q && (left_q == '0);
    sh_d   = sh_q;
    left_d = left_q;
    oe_d   = oe_q;
    if (load) begin
      oe_d = 1'b1;
      if (cls == CLS_RD8) begin
        sh_d   = {rd_data[BYTE_W-1:0], {(WORD_W-BYTE_W){1'b0}}};
        left_d = LEFT_W'(BYTE_W);
      end else begin
        sh_d   = rd_data;
        left_d = LEFT_W'(WORD_W);
      end
    end else if (left_q > LEFT_W'(1)) begin
      sh_d   = {sh_q[WORD_W-2:0], 1'b0};
      left_d = left_q - 1'b1;
    end else if (left_q == LEFT_W'(1)) begin
      left_d = '0;
      oe_d   = 1'b0;
    end
  end

  always_ff @(negedge sclk or negedge arst_n) begin
    if (!arst_n) begin
      sh_q   <= '0;
      left_q <= '0;
      oe_q   <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      left_q <= left_d;
      oe_q   <= oe_d;
    end
  end

  assign reply_q  = sh_q[WORD_W-1];
  assign reply_oe = oe_q;
endmodule

// File: rtl/sreg_serial_slave.sv
module sreg_serial_slave
  import sreg_pkg::*;
(
  input  logic              sclk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              cmd_in,
  input  logic [WORD_W-1:0] rd_data,
  output logic              reply_q,
  output logic              reply_oe,
  output logic [BYTE_W-1:0] reg_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              wr_stb,
  output logic              cmd_pulse
);
  logic     frame_rst_n;
  logic     addr_ready;
  acc_cls_e cls;

  // Deselect clears the frame just as the system reset does.
  assign frame_rst_n = rst_n & ~cs_n;

  sreg_rx u_rx (
    .sclk       (sclk),
    .arst_n     (frame_rst_n),
    .cmd_in     (cmd_in),
    .reg_addr   (reg_addr),
    .wr_data    (wr_data),
    .wr_stb     (wr_stb),
    .cmd_pulse  (cmd_pulse),
    .cls        (cls),
    .addr_ready (addr_ready)
  );

  sreg_tx u_tx (
    .sclk       (sclk),
    .arst_n     (frame_rst_n),
    .addr_ready (addr_ready),
    .cls        (cls),
    .rd_data    (rd_data),
    .reply_q    (reply_q),
    .reply_oe   (reply_oe)
  );
endmodule

// File: rtl/sreg_serial_slave_chk.sv
module sreg_serial_slave_chk (
  input logic        sclk,
  input logic        rst_n,
  input logic        cs_n,
  input logic        reply_oe,
  input logic [7:0]  reg_addr,
  input logic        wr_stb,
  input logic        cmd_pulse
);
  AST_STB_SINGLE: assert property (@(posedge sclk) disable iff (!rst_n || cs_n)
    wr_stb |=> !wr_stb); // R5
  AST_STB_WR_CLASS: assert property (@(posedge sclk) disable iff (!rst_n || cs_n)
    wr_stb |-> (reg_addr[7:6] == 2'b10)); // R3
  AST_CMD_SINGLE: assert property (@(posedge sclk) disable iff (!rst_n || cs_n)
    cmd_pulse |=> !cmd_pulse); // R2
  AST_CMD_ADDR: assert property (@(posedge sclk) disable iff (!rst_n || cs_n)
    cmd_pulse |-> (reg_addr == 8'h01)); // R2
  AST_OE_READ_ONLY: assert property (@(posedge sclk) disable iff (!rst_n || cs_n)
    reply_oe |-> (reg_addr[7:6] == 2'b11)); // R8
  AST_OE_NO_STB: assert property (@(posedge sclk) disable iff (!rst_n || cs_n)
    !(reply_oe && wr_stb)); // R8
endmodule

bind sreg_serial_slave sreg_serial_slave_chk u_chk (
  .sclk      (sclk),
  .rst_n     (rst_n),
  .cs_n      (cs_n),
  .reply_oe  (reply_oe),
  .reg_addr  (reg_addr),
  .wr_stb    (wr_stb),
  .cmd_pulse (cmd_pulse)
);

// File: tb/sreg_serial_slave_tb.sv
module sreg_serial_slave_tb;
  logic        clk = 1'b0;
  logic        sclk, rst_n, cs_n, cmd_in;
  logic [15:0] rd_data;
  logic        reply_q, reply_oe, wr_stb, cmd_pulse;
  logic [7:0]  reg_addr;
  logic [15:0] wr_data;

  int n_chk = 0, n_fail = 0;
  int wr_seen = 0, cmd_seen = 0;
  logic [7:0]  last_wa;
  logic [15:0] last_wd;
  logic        stb_prev = 1'b0, cmd_prev = 1'b0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  function automatic logic [15:0] bank_word(input logic [7:0] a);
    return {a ^ 8'hA5, a + 8'h3C};
  endfunction

  assign rd_data = bank_word(reg_addr);

  sreg_serial_slave u_dut (
    .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .cmd_in(cmd_in),
    .rd_data(rd_data), .reply_q(reply_q), .reply_oe(reply_oe),
    .reg_addr(reg_addr), .wr_data(wr_data), .wr_stb(wr_stb),
    .cmd_pulse(cmd_pulse)
  );

  always @(negedge clk) begin
    if (wr_stb && !stb_prev) begin
      wr_seen = wr_seen + 1;
      last_wa = reg_addr;
      last_wd = wr_data;
    end
    if (cmd_pulse && !cmd_prev) cmd_seen = cmd_seen + 1;
    stb_prev = wr_stb;
    cmd_prev = cmd_pulse;
  end

  task automatic chk(input bit ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // kind: 0 none, 1 cmd, 2 wr8, 3 wr16, 4 rd8, 5 rd16
  function automatic int kind_of(input logic [7:0] a);
    if (a == 8'h01) return 1;
    case (a[7:5])
      3'b100: return 2;
      3'b101: return 3;
      3'b110: return 4;
      3'b111: return 5;
      default: return 0;
    endcase
  endfunction

  task automatic xfer(input logic [7:0] a, input logic [15:0] d, input int nbits,
                      input bit idle_hi, input bit gaps);
    int          k, w0, c0, rb, ew, ec;
    logic [15:0] exp_rd, exp_wd;
    k  = kind_of(a);
    w0 = wr_seen;
    c0 = cmd_seen;
    rb = (k == 4) ? 8 : (k == 5) ? 16 : 0;
    exp_rd = (k == 4) ? {bank_word(a)[7:0], 8'h00} : bank_word(a);
    @(posedge clk) sclk <= idle_hi;
    @(posedge clk) cs_n <= 1'b0;
    for (int i = 0; i < nbits; i++) begin
      @(posedge clk);
      sclk   <= 1'b0;
      cmd_in <= (i < 8) ? a[7-i] : (i < 24) ? d[23-i] : 1'($urandom);
      @(posedge clk) sclk <= 1'b1;
      @(negedge clk);
      if (i < 8)
        chk(reply_oe == 1'b0, "R8 idle in address phase", {15'd0, reply_oe}, 16'd0);
      if (i == 7)
        chk(reg_addr == a, "R1 address byte", {8'd0, reg_addr}, {8'd0, a});
      if (rb != 0 && i >= 8 && i < 8 + rb) begin
        chk(reply_oe == 1'b1, "R6 R7 reply enabled", {15'd0, reply_oe}, 16'd1);
        chk(reply_q == exp_rd[23-i], (k == 4) ? "R6 read bit" : "R7 read bit",
            {15'd0, reply_q}, {15'd0, exp_rd[23-i]});
      end
      if (i >= 8 && i >= 8 + rb)
        chk(reply_oe == 1'b0, "R8 R9 reply released", {15'd0, reply_oe}, 16'd0);
      if (gaps && (i % 8 == 7) && ($urandom % 2 == 1))
        repeat (1 + $urandom % 5) @(posedge clk);
    end
    @(posedge clk) if (!idle_hi) sclk <= 1'b0;
    @(posedge clk) cs_n <= 1'b1;
    repeat (2) @(negedge clk);
    ew = ((k == 2 && nbits >= 16) || (k == 3 && nbits >= 24)) ? 1 : 0;
    ec = (k == 1 && nbits >= 8) ? 1 : 0;
    exp_wd = (k == 2) ? {8'h00, d[15:8]} : d;
    chk(wr_seen - w0 == ew, "R5 R9 strobe count", 16'(wr_seen - w0), 16'(ew));
    chk(cmd_seen - c0 == ec, "R2 command pulse count", 16'(cmd_seen - c0), 16'(ec));
    if (ew == 1) begin
      chk(last_wa == a, "R3 R4 strobe address", {8'd0, last_wa}, {8'd0, a});
      chk(last_wd == exp_wd, (k == 2) ? "R3 write data" : "R4 write data",
          last_wd, exp_wd);
    end
    chk(reply_oe == 1'b0 && wr_stb == 1'b0, "R8 deselected outputs",
        {14'd0, reply_oe, wr_stb}, 16'd0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int kind, full, mode, nb;
    logic [7:0] a;
    void'($urandom(32'd20417));
    sclk = 1'b0; cs_n = 1'b1; cmd_in = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(wr_stb == 0 && cmd_pulse == 0 && reply_oe == 0, "R11 reset state",
        {13'd0, wr_stb, cmd_pulse, reply_oe}, 16'd0);
    @(posedge clk) rst_n <= 1'b1;
    repeat (2) @(posedge clk);

    xfer(8'h01, 16'h0000, 8, 1'b0, 1'b0);   // R2 command, exact
    xfer(8'h01, 16'hFFFF, 24, 1'b1, 1'b0);  // R2 surplus bits ignored
    xfer(8'h8C, 16'hB700, 16, 1'b0, 1'b0);  // R3
    xfer(8'hA3, 16'h5AC3, 24, 1'b1, 1'b1);  // R4 R10
    xfer(8'hA3, 16'h1234, 23, 1'b0, 1'b0);  // R5 short by one
    xfer(8'h9F, 16'h8100, 32, 1'b1, 1'b0);  // R5 surplus
    xfer(8'hC5, 16'h0000, 16, 1'b0, 1'b0);  // R6
    xfer(8'hE9, 16'h0000, 24, 1'b1, 1'b1);  // R7 R10
    xfer(8'hD0, 16'h0000, 20, 1'b0, 1'b0);  // R8 released after last bit
    xfer(8'h00, 16'hFFFF, 24, 1'b0, 1'b0);  // R9
    xfer(8'h42, 16'hFFFF, 24, 1'b1, 1'b0);  // R9

    for (int t = 0; t < 60; t++) begin
      kind = $urandom % 6;
      case (kind)
        0: a = 8'h01;
        1: a = 8'h80 | 8'($urandom % 32);
        2: a = 8'hA0 | 8'($urandom % 32);
        3: a = 8'hC0 | 8'($urandom % 32);
        4: a = 8'hE0 | 8'($urandom % 32);
        default: begin
          a = 8'($urandom % 128);
          if (a == 8'h01) a = 8'h02;
        end
      endcase
      full = (kind == 0) ? 8 : (kind == 1 || kind == 3) ? 16 : 24;
      mode = $urandom % 4;
      nb = (mode == 0) ? full - 1 - int'($urandom % 4) : (mode == 3) ? full + 8 : full;
      if (nb < 1) nb = 1;
      xfer(a, 16'($urandom), nb, 1'($urandom), 1'($urandom));
    end
    finish_run();
  end
endmodule